// File: doc/BRIEF.md
# Five-Port Packet Router with Round-Robin Arbitration

This block is a single switching node with five ports: four ports facing neighbouring nodes and one port for the local processing element. Ports are indexed 0 to 4, which stands for ports a to e. Each input port has a four-flit buffer. A mux-based crossbar connects the buffers to the five outputs. A packet is four flits of 40 bits, 160 bits in all. The header is the first flit. Its least significant byte gives the target port in bits [2:0] and the sending port in bits [5:3]. The other 154 bits are payload, and the router passes them through unchanged.

Each output has its own round-robin arbiter. The arbiter picks among the inputs whose head packet targets that output. The winner keeps the crossbar path for all four flits of its packet. After the fourth flit is accepted, the path is released and the winner moves to the lowest priority. Both sides of every port use a valid/ready handshake. A transfer happens in a cycle where valid and ready are both high. A packet whose target field is not a legal port number is drained from its buffer and never appears on any output.

Top module: `rtr_switch5`

## Requirements
- R1: After reset, out_valid is 0 on every output and in_ready is 1 on every input. All buffers are empty, all outputs are unlocked, and every arbiter gives highest priority to port 0.
- R2: A packet is routed to the output whose index equals bits [2:0] of its header flit. Bits [5:3] of the header, which hold the source field, have no effect on routing.
- R3: Each input holds at most four flits. in_ready is 0 while four flits are held. When the router is idle, a header accepted at clock edge A is accepted at its output at edge A+2.
- R4: The four flits of a packet leave the granted output in order, back to back in acceptance order. No flit from another input is interleaved with them.
- R5: Arbitration is round-robin per output. After an input's packet completes, that output searches from the next higher port index, wrapping from 4 to 0. The input just served therefore has the lowest priority.
- R6: Packets aimed at different outputs move at the same time. One input is never connected to more than one output.
- R7: A packet whose header target field is 5, 6 or 7 is discarded. All four of its flits are removed from the buffer, nothing is driven on any output, and the next packet on that input is routed normally.
- R8: While an output has out_valid high and out_ready low, out_valid stays high and out_data stays unchanged. No flit is lost or repeated across the stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 5 | Per-input flit valid, bit p for port p |
| in_ready | output | 5 | Per-input buffer has space |
| in_data | input | 200 | Input flits, port p in bits [40p+39:40p] |
| out_valid | output | 5 | Per-output flit valid |
| out_ready | input | 5 | Per-output downstream ready |
| out_data | output | 200 | Output flits, port o in bits [40o+39:40o] |

## Verification
A lone packet carrying a non-zero source field separates correct target decoding from decoding of the wrong field, and it also pins down the two-edge buffering latency. Three inputs aimed at one output, while a fourth input targets another output, separate packet-level locking and round-robin order from flit interleaving, and parallel paths from serialised ones. A single served packet followed by a two-way tie shows whether the pointer really moves past the winner. A blocked and then toggled downstream ready, plus illegal target fields followed at once by a legal packet, show whether flits survive stalls and whether discarded packets are drained whole.

// File: rtl/rtr_pkg.sv
// Shared sizing defaults for the five-port packet router.
package rtr_pkg;
    localparam int NPORTS    = 5;   // four neighbour ports plus local port
    localparam int FLIT_W    = 40;  // bits per flit
    localparam int PKT_FLITS = 4;   // flits per packet, header first
    localparam int BUF_DEPTH = 4;   // input buffer depth in flits
    localparam int PORT_W    = 3;   // width of the port address fields
endpackage

// File: rtl/rtr_flit_fifo.sv
// Input flit buffer: a circular store that exposes its oldest entry.
// Assumes DEPTH is a power of two, push is never asserted while full,
// and pop is never asserted while empty.
module rtr_flit_fifo #(
    parameter int W     = 40,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;

    // storage write; no reset needed on data
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    // pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign head  = mem[rptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/rtr_rr_pick.sv
// Combinational round-robin selector: returns the first requester found
// when searching upward from index ptr, wrapping at N.
module rtr_rr_pick #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] ptr,
    output logic             any,
    output logic [IDX_W-1:0] win
);
    // priority search starting at the pointer
    always_comb begin
        any = 1'b0;
        win = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!any && req[idx]) begin
                any = 1'b1;
                win = IDX_W'(idx);
            end
        end
    end
endmodule

// File: rtl/rtr_out_ctrl.sv
// Per-output controller: arbitrates when unlocked, then holds the grant
// for a full packet, counting accepted flits. After the last flit it
// unlocks and moves the round-robin pointer past the served input.
// Assumes xfer is only asserted while locked.
module rtr_out_ctrl #(
    parameter int N     = 5,
    parameter int IDX_W = 3,
    parameter int FLITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic             xfer,
    output logic             lock,
    output logic [IDX_W-1:0] owner
);
    localparam int PC_W = (FLITS > 1) ? $clog2(FLITS) : 1;
    localparam logic [PC_W-1:0] LAST = PC_W'(FLITS-1);

    logic [IDX_W-1:0] ptr;
    logic [PC_W-1:0]  cnt;
    logic             any;
    logic [IDX_W-1:0] win;

    rtr_rr_pick #(.N(N), .IDX_W(IDX_W)) pick_i (
        .req (req),
        .ptr (ptr),
        .any (any),
        .win (win)
    );

    // grant, flit count and pointer state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock  <= 1'b0;
            owner <= '0;
            ptr   <= '0;
            cnt   <= '0;
        end else if (!lock) begin
            if (any) begin
                lock  <= 1'b1;
                owner <= win;
                cnt   <= '0;
            end
        end else if (xfer) begin
            if (cnt == LAST) begin
                lock <= 1'b0;
                cnt  <= '0;
                ptr  <= (int'(owner) == N-1) ? '0 : owner + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtr_switch5.sv
// Five-port packet router: per-input buffers, per-output round-robin
// controllers with packet-level locking, and a mux crossbar. Header
// flit low byte: [2:0] target port, [5:3] source port (not used for
// routing). Packets with an out-of-range target are drained silently.
module rtr_switch5
    import rtr_pkg::*;
#(
    parameter int N     = NPORTS,
    parameter int W     = FLIT_W,
    parameter int FLITS = PKT_FLITS,
    parameter int DEPTH = BUF_DEPTH,
    parameter int AW    = PORT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   in_valid,
    output logic [N-1:0]   in_ready,
    input  logic [N*W-1:0] in_data,
    output logic [N-1:0]   out_valid,
    input  logic [N-1:0]   out_ready,
    output logic [N*W-1:0] out_data
);
    localparam int IDX_W = $clog2(N);
    localparam int FC_W  = $clog2(DEPTH+1);
    localparam int PC_W  = (FLITS > 1) ? $clog2(FLITS) : 1;
    localparam logic [PC_W-1:0] LAST = PC_W'(FLITS-1);

    logic [W-1:0]      head [N];
    logic [AW-1:0]     dest [N];
    logic [PC_W-1:0]   in_cnt [N];
    logic [N-1:0]      req_mat [N];
    logic [IDX_W-1:0]  owner [N];
    logic [N-1:0]      empty, full, push, pop, fwd_pop, drop_pop;
    logic [N-1:0]      busy, bad, dropping, at_hdr;
    logic [N-1:0]      lock_vec, xfer;
    logic [N*IDX_W-1:0] owner_vec;
    logic [N*FC_W-1:0]  fifo_cnt_vec;

    genvar gi, go;
    generate
        for (gi = 0; gi < N; gi++) begin : g_in
            rtr_flit_fifo #(.W(W), .DEPTH(DEPTH)) buf_i (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (push[gi]),
                .din   (in_data[gi*W +: W]),
                .pop   (pop[gi]),
                .head  (head[gi]),
                .empty (empty[gi]),
                .full  (full[gi]),
                .count (fifo_cnt_vec[gi*FC_W +: FC_W])
            );

            assign in_ready[gi] = !full[gi];
            assign push[gi]     = in_valid[gi] && !full[gi];
            assign dest[gi]     = head[gi][AW-1:0];
            assign bad[gi]      = (dest[gi] >= AW'(N));
            assign at_hdr[gi]   = (in_cnt[gi] == '0) && !dropping[gi];
            assign drop_pop[gi] = !empty[gi] && (dropping[gi] || (at_hdr[gi] && bad[gi]));
            assign pop[gi]      = fwd_pop[gi] || drop_pop[gi];

            // packet position and discard state of this input
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    in_cnt[gi]   <= '0;
                    dropping[gi] <= 1'b0;
                end else if (pop[gi]) begin
                    if (in_cnt[gi] == LAST) begin
                        in_cnt[gi]   <= '0;
                        dropping[gi] <= 1'b0;
                    end else begin
                        in_cnt[gi] <= in_cnt[gi] + 1'b1;
                        if (drop_pop[gi]) dropping[gi] <= 1'b1;
                    end
                end
            end
        end

        for (go = 0; go < N; go++) begin : g_out
            // requests from inputs with a waiting header for this output
            always_comb begin
                for (int i = 0; i < N; i++) begin
                    req_mat[go][i] = !empty[i] && at_hdr[i] && !busy[i] && !bad[i]
                                     && (dest[i] == AW'(go));
                end
            end

            rtr_out_ctrl #(.N(N), .IDX_W(IDX_W), .FLITS(FLITS)) ctrl_i (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (req_mat[go]),
                .xfer  (xfer[go]),
                .lock  (lock_vec[go]),
                .owner (owner[go])
            );

            assign out_valid[go] = lock_vec[go] && !empty[owner[go]];
            assign xfer[go]      = out_valid[go] && out_ready[go];
            assign out_data[go*W +: W] = head[owner[go]];
            assign owner_vec[go*IDX_W +: IDX_W] = owner[go];
        end
    endgenerate

    // input occupancy by a locked output, and forwarding pops
    always_comb begin
        busy    = '0;
        fwd_pop = '0;
        for (int o = 0; o < N; o++) begin
            for (int i = 0; i < N; i++) begin
                if (lock_vec[o] && (int'(owner[o]) == i)) begin
                    busy[i] = 1'b1;
                    if (xfer[o]) fwd_pop[i] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rtr_switch5_chk.sv
// Property checker for the router, attached to every instance by bind.
// Observes ports plus the lock, owner and buffer occupancy signals.
module rtr_switch5_chk #(
    parameter int N     = 5,
    parameter int W     = 40,
    parameter int IDX_W = 3,
    parameter int FC_W  = 3,
    parameter int DEPTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     out_valid,
    input logic [N-1:0]     out_ready,
    input logic [N*W-1:0]   out_data,
    input logic [N-1:0]     lock_vec,
    input logic [N*IDX_W-1:0] owner_vec,
    input logic [N*FC_W-1:0]  fifo_cnt_vec
);
    logic [N-1:0] hit [N];

    // per-input set of outputs currently locked to it
    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int o = 0; o < N; o++) begin
                hit[i][o] = lock_vec[o] && (int'(owner_vec[o*IDX_W +: IDX_W]) == i);
            end
        end
    end

    // R1: outputs are idle in the cycle after a reset edge
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0));

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chk
            // R8: a stalled flit stays presented and unchanged
            assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid[g] && !out_ready[g]) |=>
                (out_valid[g] && $stable(out_data[g*W +: W])));

            // R3: a buffer never holds more than its depth
            assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
                fifo_cnt_vec[g*FC_W +: FC_W] <= FC_W'(DEPTH));

            // R6: an input is connected to at most one output
            assert_one_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(hit[g]) <= 1);
        end
    endgenerate
endmodule

bind rtr_switch5 rtr_switch5_chk #(
    .N(N), .W(W), .IDX_W(IDX_W), .FC_W(FC_W), .DEPTH(DEPTH)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .lock_vec     (lock_vec),
    .owner_vec    (owner_vec),
    .fifo_cnt_vec (fifo_cnt_vec)
);

// File: tb/rtr_switch5_tb_top.sv
`timescale 1ns/1ps
module rtr_switch5_tb_top;
    localparam int N = 5;
    localparam int W = 40;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   in_valid, in_ready, out_valid, out_ready;
    logic [N*W-1:0] in_data, out_data;
    logic           drv_valid [N];
    logic [W-1:0]   drv_data [N];
    logic [W-1:0]   rx [N][64];
    int             rx_cyc [N][64];
    int             rx_n [N];
    int             cyc = 0;
    int             checks = 0;
    int             errors = 0;
    bit             done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        for (int p = 0; p < N; p++) begin
            in_valid[p]         = drv_valid[p];
            in_data[p*W +: W]   = drv_data[p];
        end
    end

    rtr_switch5 dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // capture every accepted output flit away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int o = 0; o < N; o++) begin
                if (out_valid[o] && out_ready[o]) begin
                    if (rx_n[o] < 64) begin
                        rx[o][rx_n[o]]     = out_data[o*W +: W];
                        rx_cyc[o][rx_n[o]] = cyc;
                    end
                    rx_n[o] = rx_n[o] + 1;
                end
            end
        end
    end

    function automatic logic [W-1:0] mk(input logic [7:0] tag, input int k, input logic [7:0] hdr);
        logic [7:0] lo;
        lo = (k == 0) ? hdr : 8'(k * 17);
        return {tag, 8'(k), 16'hA5A5, lo};
    endfunction

    function automatic int total_rx();
        int s = 0;
        for (int o = 0; o < N; o++) s += rx_n[o];
        return s;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_pkt(input int p, input logic [7:0] hdr, input logic [7:0] tag, output int acc);
        acc = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            drv_valid[p] = 1'b1;
            drv_data[p]  = mk(tag, k, hdr);
            while (!in_ready[p]) @(negedge clk);
            @(posedge clk);
            #1;
            if (k == 0) acc = cyc;
        end
        @(negedge clk);
        drv_valid[p] = 1'b0;
    endtask

    task automatic expect_pkt(input string req, input int o, input int idx,
                              input logic [7:0] tag, input logic [7:0] hdr);
        for (int k = 0; k < 4; k++) begin
            if (idx + k < 64) check(req, rx[o][idx+k], mk(tag, k, hdr));
        end
    endtask

    task automatic idle();
        repeat (40) @(negedge clk);
    endtask

    // R1: state straight after reset
    task automatic t_reset();
        check("R1 out_valid after reset", out_valid, 5'h00);
        check("R1 in_ready after reset", in_ready, 5'h1F);
    endtask

    // R2/R3/R4: lone packet with non-zero source field, latency check
    task automatic t_single();
        int b, tot, acc;
        b = rx_n[2]; tot = total_rx();
        send_pkt(0, 8'h3A, 8'h01, acc);   // src 111, dst 010
        idle();
        check("R2 flit count at output 2", rx_n[2] - b, 4);
        check("R2 nothing on other outputs", total_rx() - tot, 4);
        expect_pkt("R4 single packet order", 2, b, 8'h01, 8'h3A);
        check("R3 header leaves two edges after acceptance", rx_cyc[2][b] - acc, 1);
    endtask

    // R4/R5/R6: three inputs to output 4, one input to output 0
    task automatic t_contend();
        int b0, b4, d1, d2, d3, d4;
        b0 = rx_n[0]; b4 = rx_n[4];
        fork
            send_pkt(2, 8'h14, 8'h21, d1);
            send_pkt(3, 8'h1C, 8'h31, d2);
            send_pkt(4, 8'h24, 8'h41, d3);
            send_pkt(1, 8'h08, 8'h11, d4);
        join
        idle();
        check("R4 output 4 flit count", rx_n[4] - b4, 12);
        expect_pkt("R5 first winner port c", 4, b4, 8'h21, 8'h14);
        expect_pkt("R5 second winner port d", 4, b4 + 4, 8'h31, 8'h1C);
        expect_pkt("R5 third winner port e", 4, b4 + 8, 8'h41, 8'h24);
        expect_pkt("R6 port b to output 0", 0, b0, 8'h11, 8'h08);
        check("R6 concurrent delivery", rx_cyc[0][b0+3] < rx_cyc[4][b4+4], 1);
    endtask

    // R5: pointer moves past the served input
    task automatic t_rotate();
        int b, d1, d2, d3;
        b = rx_n[3];
        send_pkt(0, 8'h03, 8'h02, d1);
        idle();
        fork
            send_pkt(0, 8'h03, 8'h03, d2);
            send_pkt(1, 8'h0B, 8'h12, d3);
        join
        idle();
        expect_pkt("R5 lone packet from port a", 3, b, 8'h02, 8'h03);
        expect_pkt("R5 port b wins after a served", 3, b + 4, 8'h12, 8'h0B);
        expect_pkt("R5 port a served last", 3, b + 8, 8'h03, 8'h03);
    endtask

    // R8/R3: downstream stall, full buffer, then toggled ready
    task automatic t_stall();
        int b, d;
        b = rx_n[2];
        out_ready[2] = 1'b0;
        send_pkt(3, 8'h1A, 8'h32, d);
        repeat (10) @(negedge clk);
        check("R8 no flit accepted while stalled", rx_n[2] - b, 0);
        check("R8 out_valid held while stalled", out_valid[2], 1'b1);
        check("R3 in_ready low with four flits held", in_ready[3], 1'b0);
        for (int i = 0; i < 24; i++) begin
            out_ready[2] = (i % 3 != 0);
            @(negedge clk);
        end
        out_ready[2] = 1'b1;
        idle();
        check("R8 exactly four flits after stalls", rx_n[2] - b, 4);
        expect_pkt("R8 stalled packet intact", 2, b, 8'h32, 8'h1A);
        check("R3 in_ready restored", in_ready[3], 1'b1);
    endtask

    // R7: illegal targets drained, following packet routed
    task automatic t_drop();
        int tot, b, d;
        tot = total_rx();
        send_pkt(0, 8'h05, 8'h04, d);
        send_pkt(4, 8'h27, 8'h44, d);
        idle();
        check("R7 nothing emitted for bad targets", total_rx() - tot, 0);
        b = rx_n[1];
        send_pkt(0, 8'h01, 8'h05, d);
        send_pkt(0, 8'h06, 8'h06, d);
        send_pkt(0, 8'h01, 8'h07, d);
        idle();
        check("R7 only legal packets delivered", total_rx() - tot, 8);
        expect_pkt("R7 packet after drop", 1, b, 8'h05, 8'h01);
        expect_pkt("R7 packet between drops", 1, b + 4, 8'h07, 8'h01);
    endtask

    initial begin
        for (int p = 0; p < N; p++) begin
            drv_valid[p] = 1'b0;
            drv_data[p]  = '0;
            rx_n[p]      = 0;
        end
        out_ready = 5'h1F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_contend();
        t_rotate();
        t_stall();
        t_drop();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule